// File: doc/BRIEF.md
# Selectable-Architecture FIR Filter

This block is a finite impulse response filter for signed 16-bit samples. It keeps a small set of coefficients in registers and produces `y[n] = sum over k of h[k] * x[n-k]` for each accepted sample. All arithmetic wraps modulo 2^16, so every datapath style gives exactly the same output bits.

A compile-time parameter selects one of three datapath styles.
- **Direct form:** keeps a window of past samples and forms a dot product.
- **Transposed form:** multiplies each new sample by every coefficient and passes partial sums down a register chain.
- **Pipelined form:** registers the window and the products. It takes a sample at most every other cycle and delivers each result two cycles after it takes the sample.

Coefficients are written one at a time through an address/data port while no samples are being fed.

Top module: `fir_multiform`

## Requirements
- R1: After each accepted sample, the output equals the sum over k = 0..TAPS-1 of h[k]*x[n-k], where x[n] is the newest accepted sample and samples before reset count as zero.
- R2: In direct form (ARCH=0), a sample is accepted on every clock edge where `in_valid` is high, and `out_valid` with its result appears on the following cycle.
- R3: Transposed form (ARCH=1) has the same one-cycle latency as direct form and gives bit-identical outputs for the same input stream.
- R4: The pipelined form (ARCH=2) accepts a sample only if it did not accept one on the previous edge. Its result appears with `out_valid` two cycles after acceptance, so two results are never on consecutive cycles.
- R5: In the pipelined form, a strobe on the cycle right after an accepted sample is ignored: the sample is kept out of the history. `reject_err` is high for exactly the following cycle. The other forms never raise `reject_err`.
- R6: Synchronous reset clears all sample history and partial sums, and drops `out_valid` and `reject_err`.
- R7: Asserting `coef_we` stores `coef_data` as h[`coef_addr`], where address 0 is the coefficient applied to the newest sample.
- R8: Products and sums wrap modulo 2^16 with no saturation. For example, 3 * 0x7FFF yields 0x7FFD.
- R9: History advances only on accepted samples. Idle cycles neither shift the window nor produce `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| coef_we | input | 1 | Coefficient write strobe |
| coef_addr | input | $clog2(TAPS) | Coefficient index |
| coef_data | input | W | Coefficient value, signed |
| in_valid | input | 1 | Sample strobe |
| in_sample | input | W | Input sample, signed |
| out_valid | output | 1 | Result strobe |
| out_sample | output | W | Filtered output, signed |
| reject_err | output | 1 | One-cycle pulse: a strobe was refused (pipelined form only) |

## Verification
The bench runs one instance of each of the three forms side by side on the same stream and compares every output with a reference convolution.

- **Wraparound:** large samples force the arithmetic to wrap. A design that saturated or kept extra width would differ from 0x7FFD.
- **Back-to-back strobes:** this pair exposes a pipelined form that takes the second sample, or one that drops the error pulse. The sample after the refused one then shows whether the refused value leaked into the history.
- **Coefficient order:** an impulse after a coefficient rewrite must replay the coefficients in address order. A reversed tap order fails here.
- **Mid-stream reset:** a reset in the middle of a stream must leave no stale history behind.

// File: rtl/fir_multiform.sv
module fir_multiform #(
  parameter int TAPS = 4,
  parameter int W    = 16,
  parameter int ARCH = 0
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    coef_we,
  input  logic [$clog2(TAPS)-1:0] coef_addr,
  input  logic signed [W-1:0]     coef_data,
  input  logic                    in_valid,
  input  logic signed [W-1:0]     in_sample,
  output logic                    out_valid,
  output logic signed [W-1:0]     out_sample,
  output logic                    reject_err
);
  logic signed [W-1:0] coef [TAPS];
  logic busy, accept;

  function automatic logic signed [W-1:0] mulw(logic signed [W-1:0] a, logic signed [W-1:0] b);
    logic signed [2*W-1:0] p;
    p = a * b;
    return p[W-1:0];
  endfunction

  always_ff @(posedge clk)
    if (coef_we && int'(coef_addr) < TAPS) coef[coef_addr] <= coef_data;

  assign accept = in_valid & ~busy;

  always_ff @(posedge clk)
    if (rst) reject_err <= 1'b0;
    else     reject_err <= in_valid & busy;

  generate
    if (ARCH == 1) begin : g_transposed
      logic signed [W-1:0] part [TAPS-1];
      logic signed [W-1:0] nsum [TAPS];
      assign busy = 1'b0;
      always_comb
        for (int k = 0; k < TAPS; k++)
          nsum[k] = (k == 0 ? '0 : part[k-1]) + mulw(coef[TAPS-1-k], in_sample);
      always_ff @(posedge clk)
        if (rst) begin
          for (int k = 0; k < TAPS-1; k++) part[k] <= '0;
          out_valid  <= 1'b0;
          out_sample <= '0;
        end else begin
          out_valid <= accept;
          if (accept) begin
            for (int k = 0; k < TAPS-1; k++) part[k] <= nsum[k];
            out_sample <= nsum[TAPS-1];
          end
        end
    end else begin : g_window
      logic signed [W-1:0] hist [TAPS];
      logic signed [W-1:0] nw   [TAPS];
      always_comb begin
        nw[0] = in_sample;
        for (int i = 1; i < TAPS; i++) nw[i] = hist[i-1];
      end
      always_ff @(posedge clk)
        if (rst) for (int i = 0; i < TAPS; i++) hist[i] <= '0;
        else if (accept) hist <= nw;

      if (ARCH == 2) begin : g_pipelined
        logic signed [W-1:0] prod [TAPS];
        logic signed [W-1:0] acc;
        logic v1;
        always_comb begin
          acc = '0;
          for (int i = 0; i < TAPS; i++) acc = acc + prod[i];
        end
        always_ff @(posedge clk)
          if (rst) begin
            busy <= 1'b0;
            v1   <= 1'b0;
            for (int i = 0; i < TAPS; i++) prod[i] <= '0;
            out_valid  <= 1'b0;
            out_sample <= '0;
          end else begin
            busy      <= accept;
            v1        <= accept;
            out_valid <= v1;
            if (accept)
              for (int i = 0; i < TAPS; i++) prod[i] <= mulw(coef[i], nw[i]);
            if (v1) out_sample <= acc;
          end
      end else begin : g_direct
        logic signed [W-1:0] acc;
        assign busy = 1'b0;
        always_comb begin
          acc = '0;
          for (int i = 0; i < TAPS; i++) acc = acc + mulw(coef[i], nw[i]);
        end
        always_ff @(posedge clk)
          if (rst) begin
            out_valid  <= 1'b0;
            out_sample <= '0;
          end else begin
            out_valid <= accept;
            if (accept) out_sample <= acc;
          end
      end
    end
  endgenerate
endmodule

// File: rtl/fir_multiform_chk.sv
module fir_multiform_chk #(
  parameter int ARCH = 0
) (
  input logic clk,
  input logic rst,
  input logic in_valid,
  input logic out_valid,
  input logic reject_err
);
  a_r6_reset_clears: assert property (@(posedge clk) rst |=> !out_valid && !reject_err);
  a_r5_err_has_cause: assert property (@(posedge clk) disable iff (rst) reject_err |-> $past(in_valid));
  a_r5_err_one_cycle: assert property (@(posedge clk) disable iff (rst) reject_err |=> !reject_err);

  generate
    if (ARCH == 2) begin : g_pipe
      a_r4_no_adjacent_results: assert property (@(posedge clk) disable iff (rst) out_valid |=> !out_valid);
      a_r4_two_cycle_latency: assert property (@(posedge clk) disable iff (rst) out_valid |-> $past(in_valid, 2));
    end else begin : g_single
      a_r2_next_cycle_result: assert property (@(posedge clk) disable iff (rst) in_valid |=> out_valid);
      a_r9_no_spurious_result: assert property (@(posedge clk) disable iff (rst) out_valid |-> $past(in_valid));
      a_r5_never_rejects: assert property (@(posedge clk) disable iff (rst) !reject_err);
    end
  endgenerate
endmodule

bind fir_multiform fir_multiform_chk #(.ARCH(ARCH)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .out_valid(out_valid), .reject_err(reject_err)
);

// File: tb/fir_multiform_test.sv
module fir_multiform_test;
  localparam int CLK_PERIOD = 10;
  localparam int TAPS = 4;
  localparam int NSTIM = 10;
  localparam logic signed [15:0] STIM [NSTIM] = '{
    16'sd1, 16'sd0, 16'sd0, 16'sd0, 16'sd0, -16'sd4, 16'sd100,
    16'sh7fff, 16'sh7fff, -16'sh8000};

  logic clk = 1'b0, rst = 1'b1, coef_we = 1'b0, in_valid = 1'b0;
  logic [1:0] coef_addr = '0;
  logic signed [15:0] coef_data = '0, in_sample = '0;
  logic ov_d, ov_t, ov_s, er_d, er_t, er_s;
  logic signed [15:0] y_d, y_t, y_s;
  int checks = 0, errors = 0;
  logic done = 1'b0;

  logic signed [15:0] coef_m [TAPS];
  logic signed [15:0] hd [TAPS];
  logic signed [15:0] hs [TAPS];

  always #(CLK_PERIOD/2) clk = ~clk;

  fir_multiform #(.TAPS(TAPS), .W(16), .ARCH(0)) uut (
    .clk(clk), .rst(rst), .coef_we(coef_we), .coef_addr(coef_addr), .coef_data(coef_data),
    .in_valid(in_valid), .in_sample(in_sample), .out_valid(ov_d), .out_sample(y_d), .reject_err(er_d));
  fir_multiform #(.TAPS(TAPS), .W(16), .ARCH(1)) uut_tr (
    .clk(clk), .rst(rst), .coef_we(coef_we), .coef_addr(coef_addr), .coef_data(coef_data),
    .in_valid(in_valid), .in_sample(in_sample), .out_valid(ov_t), .out_sample(y_t), .reject_err(er_t));
  fir_multiform #(.TAPS(TAPS), .W(16), .ARCH(2)) uut_sy (
    .clk(clk), .rst(rst), .coef_we(coef_we), .coef_addr(coef_addr), .coef_data(coef_data),
    .in_valid(in_valid), .in_sample(in_sample), .out_valid(ov_s), .out_sample(y_s), .reject_err(er_s));

  task automatic chk(string tag, logic signed [15:0] act, logic signed [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic signed [15:0] dot(logic signed [15:0] h [TAPS]);
    logic signed [15:0] s = '0;
    for (int i = 0; i < TAPS; i++) s = s + 16'(32'(coef_m[i]) * 32'(h[i]));
    return s;
  endfunction

  task automatic shift_d(logic signed [15:0] x, output logic signed [15:0] e);
    for (int i = TAPS-1; i > 0; i--) hd[i] = hd[i-1];
    hd[0] = x;
    e = dot(hd);
  endtask

  task automatic shift_s(logic signed [15:0] x, output logic signed [15:0] e);
    for (int i = TAPS-1; i > 0; i--) hs[i] = hs[i-1];
    hs[0] = x;
    e = dot(hs);
  endtask

  task automatic clear_models();
    for (int i = 0; i < TAPS; i++) begin hd[i] = '0; hs[i] = '0; end
  endtask

  task automatic write_coefs(logic signed [15:0] c0, logic signed [15:0] c1,
                             logic signed [15:0] c2, logic signed [15:0] c3);
    logic signed [15:0] c [TAPS];
    c = '{c0, c1, c2, c3};
    for (int i = 0; i < TAPS; i++) begin
      coef_we = 1'b1; coef_addr = 2'(i); coef_data = c[i]; coef_m[i] = c[i];
      @(posedge clk); #1;
    end
    coef_we = 1'b0;
  endtask

  // One sample, then an idle cycle; checks all three forms.
  task automatic push(logic signed [15:0] x, string tag);
    logic signed [15:0] ed, es;
    shift_d(x, ed);
    shift_s(x, es);
    in_valid = 1'b1; in_sample = x;
    @(posedge clk); #1;
    in_valid = 1'b0;
    chk({tag, " R2 direct valid"}, 16'(ov_d), 16'd1);
    chk({tag, " R1 direct value"}, y_d, ed);
    chk({tag, " R3 transposed value"}, y_t, ed);
    chk({tag, " R4 pipelined not yet valid"}, 16'(ov_s), 16'd0);
    @(posedge clk); #1;
    chk({tag, " R4 pipelined valid"}, 16'(ov_s), 16'd1);
    chk({tag, " R4 pipelined value"}, y_s, es);
    chk({tag, " R9 direct idle"}, 16'(ov_d), 16'd0);
  endtask

  initial begin
    clear_models();
    repeat (3) @(posedge clk);
    #1;
    // R6: reset state
    chk("R6 out_valid direct", 16'(ov_d), 16'd0);
    chk("R6 out_valid transposed", 16'(ov_t), 16'd0);
    chk("R6 out_valid pipelined", 16'(ov_s), 16'd0);
    chk("R6 reject_err pipelined", 16'(er_s), 16'd0);
    rst = 1'b0;
    write_coefs(16'sd3, -16'sd2, 16'sd5, 16'sd7);

    // R1/R9 table walk, including wrapping values (R8)
    for (int n = 0; n < NSTIM; n++) push(STIM[n], "table");

    // R8: wraparound from a clean history
    rst = 1'b1; @(posedge clk); #1; rst = 1'b0; clear_models();
    push(16'sh7fff, "wrap");
    chk("R8 wrap literal", y_d, 16'sh7ffd);

    // R2/R5: back-to-back strobes
    begin
      logic signed [15:0] ea, eb, es, ec, esc;
      shift_d(16'sd11, ea);
      shift_s(16'sd11, es);
      in_valid = 1'b1; in_sample = 16'sd11;
      @(posedge clk); #1;
      chk("R2 b2b first direct", y_d, ea);
      in_sample = 16'sd22;
      shift_d(16'sd22, eb);
      @(posedge clk); #1;
      in_valid = 1'b0;
      chk("R2 b2b second direct valid", 16'(ov_d), 16'd1);
      chk("R2 b2b second direct", y_d, eb);
      chk("R3 b2b second transposed", y_t, eb);
      chk("R5 reject_err raised", 16'(er_s), 16'd1);
      chk("R5 transposed no reject", 16'(er_t), 16'd0);
      chk("R4 b2b pipelined result", y_s, es);
      chk("R4 b2b pipelined valid", 16'(ov_s), 16'd1);
      @(posedge clk); #1;
      chk("R5 reject_err one cycle", 16'(er_s), 16'd0);
      chk("R5 refused sample makes no result", 16'(ov_s), 16'd0);
      // The next sample shows whether 22 entered the pipelined history.
      shift_d(16'sd33, ec);
      shift_s(16'sd33, esc);
      in_valid = 1'b1; in_sample = 16'sd33;
      @(posedge clk); #1;
      in_valid = 1'b0;
      chk("R2 after b2b direct", y_d, ec);
      @(posedge clk); #1;
      chk("R5 refused sample kept out of history", y_s, esc);
    end

    // R6: reset in mid-stream leaves no history
    push(16'sd9, "pre-reset");
    rst = 1'b1; @(posedge clk); #1; rst = 1'b0; clear_models();
    chk("R6 mid-stream valid dropped", 16'(ov_d), 16'd0);
    push(16'sd1, "post-reset");
    chk("R6 impulse after reset", y_d, coef_m[0]);

    // R7: reload coefficients, impulse replays them in address order
    rst = 1'b1; @(posedge clk); #1; rst = 1'b0; clear_models();
    write_coefs(16'sd1, 16'sd2, 16'sd3, 16'sd4);
    for (int k = 0; k < TAPS; k++) begin
      push(k == 0 ? 16'sd1 : 16'sd0, "impulse");
      chk("R7 impulse tap direct", y_d, 16'(k + 1));
      chk("R7 impulse tap transposed", y_t, 16'(k + 1));
      chk("R7 impulse tap pipelined", y_s, 16'(k + 1));
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule